// File: doc/BRIEF.md
# DTMF Squarewave Frequency Classifier

This block takes two clean, limited squarewaves: one carrying the low-group tone of a DTMF pair and one carrying the high-group tone. It times every input period in cycles of the system clock. The system clock is nominally 4.194304 MHz and is set by a parameter. The block adds up eight consecutive periods and compares that sum against a window for each of the four nominal frequencies of the group. The window is the accept band of that frequency scaled to eight periods.

A group holds a valid frequency from the end of an in-band measurement window until one of two events:

- a later window lands outside every band;
- no rising edge arrives for twice the longest acceptable period.

When both groups hold a valid frequency, the early steering output rises and a 4-bit digit code is latched. The code stays fixed until steering drops. Guard-time validation and the serial readout of the code are left to downstream logic.

Top module: `dtmf_freq_classifier`

## Requirements
- R1: During and after reset, `est` is 0 and `digit` is 4'b0000.
- R2: A low-group tone whose frequency lies within ±(1.5 % + 2 Hz) of 697, 770, 852 or 941 Hz is recognised as row index 0, 1, 2 or 3. Recognition is judged on the sum of 8 consecutive rising-edge-to-rising-edge periods, never on one period.
- R3: A high-group tone within ±(1.5 % + 2 Hz) of 1209, 1336, 1477 or 1633 Hz is recognised as column index 0, 1, 2 or 3, using the same 8-period sum.
- R4: A tone that is 3.5 % or more away from every nominal frequency of its group is not recognised, and `est` stays 0.
- R5: A tone that lies between the accept band and the reject band of a nominal frequency is also treated as not recognised, so `est` does not rise for it.
- R6: `est` is 1 only while both groups hold a recognised frequency. It returns to 0 after either group loses its frequency, and it stays 0 when only one group is present.
- R7: When `est` rises, `digit` takes the code for the row and column pair:
  - Rows 0–2 with columns 0–2 give 1 to 9 in row-major order.
  - Row 3 gives 11, 10 and 12 for columns 0, 1 and 2.
  - Column 3 gives 13, 14 and 15 for rows 0, 1 and 2, and 0 for row 3.
- R8: A group with no rising edge for twice the longest acceptable low-group period loses its frequency. At CLK_HZ = 131072 this limit is 382 cycles. The group keeps its frequency for any shorter gap.
- R9: `digit` does not change while `est` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all period counts use this clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lo_sq | input | 1 | Limited low-group squarewave (asynchronous) |
| hi_sq | input | 1 | Limited high-group squarewave (asynchronous) |
| est | output | 1 | Early steering: both groups hold a recognised frequency |
| digit | output | 4 | Decoded digit code, latched when `est` rises |

## Verification
The hardest case to produce from the ports is a tone that sits in the gap between acceptance and rejection. Such a tone must give no steering and must not be taken for a neighbouring nominal frequency. The bench drives squarewaves with integer periods chosen so that the 8-period sum falls just outside the accept window of the nearest tone and still inside its reject limit. It does this once in each group, and adds one tone placed between two high-group frequencies.

The timeout edge is reached by silencing one group while the other keeps running. The bench then samples steering 300 cycles after the last driven rising edge, when it must still be high, and again at 450 cycles, when it must be low.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

  localparam int unsigned GRP_TONES = 4;
  localparam int unsigned IDX_W     = 2;
  localparam int unsigned CODE_W    = 4;

  // Accept band edges of a nominal frequency, in milli-hertz.
  function automatic longint unsigned band_top_mhz(input longint unsigned f_hz);
    return f_hz * 64'd1015 + 64'd2000;
  endfunction

  function automatic longint unsigned band_bot_mhz(input longint unsigned f_hz);
    return f_hz * 64'd985 - 64'd2000;
  endfunction

  // Smallest accepted sum of n periods (highest accepted frequency), rounded up.
  function automatic longint unsigned sum_floor(input longint unsigned clk_hz,
                                                input longint unsigned n,
                                                input longint unsigned f_hz);
    longint unsigned num;
    num = clk_hz * n * 64'd1000;
    return (num + band_top_mhz(f_hz) - 64'd1) / band_top_mhz(f_hz);
  endfunction

  // Largest accepted sum of n periods (lowest accepted frequency), rounded down.
  function automatic longint unsigned sum_ceil(input longint unsigned clk_hz,
                                               input longint unsigned n,
                                               input longint unsigned f_hz);
    longint unsigned num;
    num = clk_hz * n * 64'd1000;
    return num / band_bot_mhz(f_hz);
  endfunction

  // Row/column pair to 4-bit digit code.
  function automatic logic [CODE_W-1:0] digit_code(input logic [IDX_W-1:0] row,
                                                   input logic [IDX_W-1:0] col);
    logic [CODE_W-1:0] c;
    if (col == 2'd3) begin
      c = (row == 2'd3) ? 4'd0 : (4'd13 + {2'b00, row});
    end else if (row == 2'd3) begin
      case (col)
        2'd0:    c = 4'd11;
        2'd1:    c = 4'd10;
        default: c = 4'd12;
      endcase
    end else begin
      c = {2'b00, row} * 4'd3 + {2'b00, col} + 4'd1;
    end
    return c;
  endfunction

endpackage

// File: rtl/edge_rise_det.sv
module edge_rise_det #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_in,
  output logic rise
);
  logic [SYNC_N:0] sync_q;
  logic [SYNC_N:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[SYNC_N-1:0], sq_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nx;
  end

  assign rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
endmodule

// File: rtl/tone_period_acc.sv
module tone_period_acc #(
  parameter int unsigned AVG_N = 8,
  parameter int unsigned TMO   = 6000,
  parameter int unsigned CNT_W = 13,
  parameter int unsigned SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic             armed,
  output logic             win_done,
  output logic [SUM_W-1:0] win_sum,
  output logic             lost
);
  localparam int unsigned NW = $clog2(AVG_N + 1);

  logic             armed_q, armed_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [SUM_W-1:0] acc_q, acc_nx, acc_add;
  logic [NW-1:0]    n_q, n_nx;

  // The period just ended is cnt_q + 1 cycles long.
  assign acc_add = acc_q + SUM_W'(cnt_q) + SUM_W'(1);

  always_comb begin
    armed_nx = armed_q;
    cnt_nx   = cnt_q;
    acc_nx   = acc_q;
    n_nx     = n_q;
    win_done = 1'b0;
    lost     = 1'b0;
    win_sum  = acc_add;
    if (!armed_q) begin
      if (rise) begin
        armed_nx = 1'b1;
        cnt_nx   = '0;
        acc_nx   = '0;
        n_nx     = '0;
      end
    end else if (rise) begin
      cnt_nx = '0;
      if (n_q == NW'(AVG_N - 1)) begin
        win_done = 1'b1;
        acc_nx   = '0;
        n_nx     = '0;
      end else begin
        acc_nx = acc_add;
        n_nx   = n_q + NW'(1);
      end
    end else if (cnt_q == CNT_W'(TMO - 1)) begin
      lost     = 1'b1;
      armed_nx = 1'b0;
    end else begin
      cnt_nx = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= '0;
      n_q     <= '0;
    end else begin
      armed_q <= armed_nx;
      cnt_q   <= cnt_nx;
      acc_q   <= acc_nx;
      n_q     <= n_nx;
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/tone_band_match.sv
module tone_band_match
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned CLK_HZ = 4194304,
  parameter int unsigned AVG_N  = 8,
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned FREQ [GRP_TONES] = '{697, 770, 852, 941}
) (
  input  logic [SUM_W-1:0]     win_sum,
  output logic [GRP_TONES-1:0] hit,
  output logic [IDX_W-1:0]     hit_idx
);
  for (genvar i = 0; i < GRP_TONES; i++) begin : g_band
    localparam logic [SUM_W-1:0] LO_C = SUM_W'(sum_floor(CLK_HZ, AVG_N, FREQ[i]));
    localparam logic [SUM_W-1:0] HI_C = SUM_W'(sum_ceil(CLK_HZ, AVG_N, FREQ[i]));
    assign hit[i] = (win_sum >= LO_C) && (win_sum <= HI_C);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = GRP_TONES - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tone_group_cls.sv
module tone_group_cls
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned CLK_HZ = 4194304,
  parameter int unsigned AVG_N  = 8,
  parameter int unsigned TMO    = 12000,
  parameter int unsigned FREQ [GRP_TONES] = '{697, 770, 852, 941}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_in,
  output logic             tone_ok,
  output logic [IDX_W-1:0] tone_idx
);
  localparam int unsigned CNT_W = $clog2(TMO + 1);
  localparam int unsigned SUM_W = $clog2(AVG_N * TMO + 1);

  logic                 rise, armed, win_done, lost;
  logic [SUM_W-1:0]     win_sum;
  logic [GRP_TONES-1:0] hit;
  logic [IDX_W-1:0]     hit_idx;
  logic                 ok_q, ok_nx;
  logic [IDX_W-1:0]     idx_q, idx_nx;

  edge_rise_det #(.SYNC_N(2)) i_rise (
    .clk(clk), .rst_n(rst_n), .sq_in(sq_in), .rise(rise)
  );

  tone_period_acc #(.AVG_N(AVG_N), .TMO(TMO), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .rise(rise), .armed(armed),
    .win_done(win_done), .win_sum(win_sum), .lost(lost)
  );

  tone_band_match #(.CLK_HZ(CLK_HZ), .AVG_N(AVG_N), .SUM_W(SUM_W), .FREQ(FREQ)) i_match (
    .win_sum(win_sum), .hit(hit), .hit_idx(hit_idx)
  );

  always_comb begin
    ok_nx  = ok_q;
    idx_nx = idx_q;
    if (lost) begin
      ok_nx = 1'b0;
    end else if (win_done) begin
      ok_nx = |hit;
      if (|hit) idx_nx = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      ok_q  <= ok_nx;
      idx_q <= idx_nx;
    end
  end

  assign tone_ok  = ok_q;
  assign tone_idx = idx_q;

  // R8: a held frequency needs an edge tracker that has not timed out
  a_r8_ok_needs_track: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> armed);

  // R2, R3: an 8-period sum may match at most one nominal band
  a_r2_bands_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> $onehot0(hit));
endmodule

// File: rtl/dtmf_freq_classifier.sv
module dtmf_freq_classifier
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned CLK_HZ = 4194304,
  parameter int unsigned AVG_N  = 8,
  parameter int unsigned LO_FREQ [GRP_TONES] = '{697, 770, 852, 941},
  parameter int unsigned HI_FREQ [GRP_TONES] = '{1209, 1336, 1477, 1633}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_sq,
  input  logic              hi_sq,
  output logic              est,
  output logic [CODE_W-1:0] digit
);
  // Silence limit: twice the longest acceptable low-group period.
  localparam int unsigned TMO = int'(sum_ceil(CLK_HZ, 2, LO_FREQ[0]));

  logic              lo_ok, hi_ok;
  logic [IDX_W-1:0]  lo_idx, hi_idx;
  logic              est_q, est_nx;
  logic [CODE_W-1:0] digit_q, digit_nx;

  tone_group_cls #(.CLK_HZ(CLK_HZ), .AVG_N(AVG_N), .TMO(TMO), .FREQ(LO_FREQ)) i_lo (
    .clk(clk), .rst_n(rst_n), .sq_in(lo_sq), .tone_ok(lo_ok), .tone_idx(lo_idx)
  );

  tone_group_cls #(.CLK_HZ(CLK_HZ), .AVG_N(AVG_N), .TMO(TMO), .FREQ(HI_FREQ)) i_hi (
    .clk(clk), .rst_n(rst_n), .sq_in(hi_sq), .tone_ok(hi_ok), .tone_idx(hi_idx)
  );

  always_comb begin
    est_nx   = lo_ok & hi_ok;
    digit_nx = digit_q;
    if (lo_ok && hi_ok && !est_q) digit_nx = digit_code(lo_idx, hi_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q   <= 1'b0;
      digit_q <= '0;
    end else begin
      est_q   <= est_nx;
      digit_q <= digit_nx;
    end
  end

  assign est   = est_q;
  assign digit = digit_q;

  // R9: code frozen while steering stays high
  a_r9_digit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (est_q && $past(est_q)) |-> $stable(digit_q));

  // R6: losing the low-group tone ends steering
  a_r6_est_drop_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_ok) |=> !est_q);
endmodule

// File: tb/test_dtmf_freq_classifier.sv
`timescale 1ns/1ps

module tb_tone_src (
  input  logic clk,
  input  int   per,
  input  int   cyc,
  output logic sq,
  output int   last_rise,
  output logic idle
);
  initial begin
    int p;
    sq = 1'b0;
    idle = 1'b1;
    last_rise = 0;
    forever begin
      @(posedge clk);
      if (per > 1) begin
        p = per;
        idle = 1'b0;
        sq <= 1'b1;
        last_rise = cyc;
        repeat (p / 2) @(posedge clk);
        sq <= 1'b0;
        repeat (p - p / 2 - 1) @(posedge clk);
      end else begin
        idle = 1'b1;
      end
    end
  end
endmodule

module test_dtmf_freq_classifier;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lo_sq, hi_sq;
  logic       est;
  logic [3:0] digit;
  int lo_per = 0, hi_per = 0, cyc = 0;
  int lo_last, hi_last;
  logic lo_idle, hi_idle;
  int checks = 0, failures = 0, hold_err = 0;
  logic est_prev = 1'b0;
  logic [3:0] dig_prev = 4'd0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtmf_freq_classifier #(.CLK_HZ(131072)) i_dtmf_freq_classifier (
    .clk(clk), .rst_n(rst_n), .lo_sq(lo_sq), .hi_sq(hi_sq), .est(est), .digit(digit)
  );

  tb_tone_src i_lo_src (.clk(clk), .per(lo_per), .cyc(cyc), .sq(lo_sq), .last_rise(lo_last), .idle(lo_idle));
  tb_tone_src i_hi_src (.clk(clk), .per(hi_per), .cyc(cyc), .sq(hi_sq), .last_rise(hi_last), .idle(hi_idle));

  // At CLK_HZ = 131072: low periods 188/170/154/139, high periods 108/98/89/80.
  // Fields: [22:14] low period, [13:5] high period, [4] steering, [3:0] code.
  localparam int NV = 22;
  localparam logic [22:0] VEC [NV] = '{
    {9'd188, 9'd108, 1'b1, 4'd1},  {9'd188, 9'd98, 1'b1, 4'd2},  {9'd188, 9'd89, 1'b1, 4'd3},
    {9'd170, 9'd108, 1'b1, 4'd4},  {9'd170, 9'd98, 1'b1, 4'd5},  {9'd170, 9'd89, 1'b1, 4'd6},
    {9'd154, 9'd108, 1'b1, 4'd7},  {9'd154, 9'd98, 1'b1, 4'd8},  {9'd154, 9'd89, 1'b1, 4'd9},
    {9'd139, 9'd98,  1'b1, 4'd10}, {9'd139, 9'd108, 1'b1, 4'd11}, {9'd139, 9'd89, 1'b1, 4'd12},
    {9'd188, 9'd80,  1'b1, 4'd13}, {9'd170, 9'd80, 1'b1, 4'd14}, {9'd154, 9'd80, 1'b1, 4'd15},
    {9'd139, 9'd80,  1'b1, 4'd0},
    {9'd183, 9'd108, 1'b0, 4'd0},  // low in gap above 697 (R5)
    {9'd179, 9'd108, 1'b0, 4'd0},  // low 5 % above 697 (R4)
    {9'd188, 9'd111, 1'b0, 4'd0},  // high in gap below 1209 (R5)
    {9'd188, 9'd76,  1'b0, 4'd0},  // high 5.6 % above 1633 (R4)
    {9'd170, 9'd94,  1'b0, 4'd0},  // high between 1336 and 1477 (R4)
    {9'd188, 9'd0,   1'b0, 4'd0}   // low group only (R6)
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9 monitor: code must not move while steering stays high
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (est && est_prev && digit != dig_prev) hold_err++;
      est_prev = est;
      dig_prev = digit;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 est in reset", int'(est), 0);
    check("R1 digit in reset", int'(digit), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 est after reset", int'(est), 0);
    check("R1 digit after reset", int'(digit), 0);

    for (int v = 0; v < NV; v++) begin
      lo_per = int'(VEC[v][22:14]);
      hi_per = int'(VEC[v][13:5]);
      repeat (3760) @(negedge clk);
      check($sformatf("R2 R3 R4 R5 R6 est vec %0d", v), int'(est), int'(VEC[v][4]));
      if (VEC[v][4]) check($sformatf("R7 digit vec %0d", v), int'(digit), int'(VEC[v][3:0]));
      lo_per = 0;
      hi_per = 0;
      repeat (800) @(negedge clk);
      check($sformatf("R6 est after silence vec %0d", v), int'(est), 0);
    end

    // R8: silence the low group while the high group keeps running
    lo_per = 170;
    hi_per = 98;
    repeat (3760) @(negedge clk);
    check("R8 est before silence", int'(est), 1);
    check("R7 digit before silence", int'(digit), 5);
    lo_per = 0;
    wait (lo_idle == 1'b1);
    while (cyc < lo_last + 300) @(negedge clk);
    check("R8 est held 300 cycles after last edge", int'(est), 1);
    while (cyc < lo_last + 450) @(negedge clk);
    check("R8 est dropped 450 cycles after last edge", int'(est), 0);
    hi_per = 0;
    repeat (600) @(negedge clk);

    check("R9 digit changes during steering", hold_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule